// File: doc/BRIEF.md
# Register-Driven Serial Management Master

This block lets software reach the management registers of a serial transceiver over a two-wire clock-and-data link. It presents two 32-bit registers on a simple write strobe and select bus with combinational read-back. The settings register holds the management clock divisor, a preamble enable and a read-only completion flag. The command register takes a command word. When software writes a command word with its start bit set, the block serialises a clause-22-style read or write frame on the management clock and data lines. On a read, it places the 16 returned bits in the low half of the command register and then raises the completion flag.

A layout-select input picks one of two decodings of the device and register address fields in the command word. This lets one driver serve both older and newer transceiver blocks. To select a sub-block on the newer layout, software issues a write to device 0, register 0x1F, with the block number placed from bit 4 of the data.

The control sequencer has three states. IDLE goes to PREAMBLE on a launch when the preamble is enabled, and to SHIFT on a launch when it is not. PREAMBLE goes to SHIFT after the last of its 32 one-bits. SHIFT goes back to IDLE after the falling clock edge that ends the last frame bit.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, both registers read back zero, the management clock is low and the data line is not driven (`mdio_oe` = 0).
- R2: The settings register is `reg_sel`=0. Bits [6:0] hold the divisor, bit 7 enables the preamble and bit 8 is the completion flag. Bit 8 cannot be written and reads as 0 after reset. All bits above 8 read as 0.
- R3: The command register is `reg_sel`=1. An idle write stores the whole word. When bit 30 (start) is clear, no frame is launched: the clock stays low and the completion flag is unchanged.
- R4: An idle write to the command register with bit 30 set launches a frame, and the completion flag reads 0 in the cycle after the write. Bit 29 set selects a read; otherwise the frame is a write. The frame is sent most significant bit first as: start 01, opcode (01 write, 10 read), 5 device bits, 5 register bits, turnaround (10 on a write) and 16 data bits (command bits [15:0] on a write).
- R5: The management clock starts low and toggles once every divisor+1 system clocks while a frame runs. The completion flag reads 1 exactly 2·N·(divisor+1) clocks after the launching edge, where N is the number of frame bits.
- R6: With bit 7 set, the frame is preceded by 32 driven one-bits, so N = 64; with bit 7 clear, N = 32.
- R7: On a read, the data line is released from the first turnaround bit through the end of the frame. The data is sampled on each rising edge of the management clock. At completion, command bits [15:0] take the sampled value and bits [31:16] keep the written word.
- R8: With `legacy_sel`=0, the device address is command bits [27:23] and the register address is bits [22:18]. With `legacy_sel`=1, the device field is bits [27:22], of which bits [26:22] are sent, and the register address is bits [21:18] with a leading 0.
- R9: Any register write while a frame is in progress has no effect, including a write that lands on the edge that completes the frame. Such a write neither alters the frame nor the stored word, and starts no new frame.
- R10: Outside a frame, the management clock is low and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 settings, 1 command |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| legacy_sel | input | 1 | Address-field layout select, sampled at launch |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_in | input | 1 | Management data line as seen from the pad |

## Verification
Two functions can fall in the same clock edge: completion of a read frame, which writes the captured data into the command register and sets the flag, and a new software write to the command register. The bench lands a start-bit write on the computed completion edge of a preambled read. It then checks that the register holds the captured read value, that the flag is 1, and that the management clock stays low with no second frame appearing on the line. A second read receives a write a few cycles after launch, and its frame and result are judged unchanged.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int REG_W         = 32;
    localparam int DIV_W         = 7;
    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 5;
    localparam int FRAME_BITS    = 32;
    localparam int PREAMBLE_BITS = 32;
    localparam int BIT_START     = 30;
    localparam int BIT_READ      = 29;
    localparam int BIT_PRE_EN    = 7;
    localparam int BIT_DONE      = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SHIFT
    } mdio_state_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick      = run && (cnt_q == div);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the clock only moves on a divider wrap
    assert_mdc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_cmd_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int PRE_W   = PREAMBLE_BITS,
    parameter int DW      = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rd_in,
    input  logic               pre_in,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_in,
    output logic               busy,
    output logic               finish,
    output logic [DW-1:0]      rd_data,
    output logic               mdio_out,
    output logic               mdio_oe
);
    localparam int SPAN  = (FRAME_W > PRE_W) ? FRAME_W : PRE_W;
    localparam int CNT_W = $clog2(SPAN);
    localparam logic [CNT_W-1:0] IDX_LAST_FRM = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] IDX_LAST_PRE = CNT_W'(PRE_W - 1);
    localparam logic [CNT_W-1:0] IDX_RELEASE  = CNT_W'(FRAME_W - DW - 2);
    localparam logic [CNT_W-1:0] IDX_CAPTURE  = CNT_W'(FRAME_W - DW);

    mdio_state_t        state_q, state_d;
    logic [CNT_W-1:0]   idx_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               rd_q;
    logic [DW-1:0]      rdsh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch) state_d = pre_in ? ST_PREAMBLE : ST_SHIFT;
            ST_PREAMBLE: if (fall_tick && idx_q == IDX_LAST_PRE) state_d = ST_SHIFT;
            ST_SHIFT:    if (fall_tick && idx_q == IDX_LAST_FRM) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shreg_q <= '0;
            rd_q    <= 1'b0;
            rdsh_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    idx_q   <= '0;
                    shreg_q <= frame_in;
                    rd_q    <= rd_in;
                    rdsh_q  <= '0;
                end
                ST_PREAMBLE: if (fall_tick)
                    idx_q <= (idx_q == IDX_LAST_PRE) ? '0 : idx_q + 1'b1;
                ST_SHIFT: begin
                    if (fall_tick) begin
                        idx_q   <= (idx_q == IDX_LAST_FRM) ? '0 : idx_q + 1'b1;
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                    end
                    if (rise_tick && rd_q && idx_q >= IDX_CAPTURE)
                        rdsh_q <= {rdsh_q[DW-2:0], mdio_in};
                end
                default: idx_q <= '0;
            endcase
        end
    end

    always_comb begin
        mdio_out = 1'b0;
        mdio_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_out = 1'b0;
                mdio_oe  = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_out = 1'b1;
                mdio_oe  = 1'b1;
            end
            ST_SHIFT: begin
                mdio_out = shreg_q[FRAME_W-1];
                mdio_oe  = !(rd_q && idx_q >= IDX_RELEASE);
            end
            default: begin
                mdio_out = 1'b0;
                mdio_oe  = 1'b0;
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign finish  = (state_q == ST_SHIFT) && fall_tick && (idx_q == IDX_LAST_FRM);
    assign rd_data = rdsh_q;

    // entering the turnaround of a read frees the line
    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && rd_q && fall_tick && idx_q == IDX_RELEASE - 1'b1)
        |=> !mdio_oe);
    // the register side only launches into an idle sequencer
    assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (state_q == ST_IDLE));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              legacy_sel,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int PAD_W = REG_W - DIV_W - 2;

    logic [DIV_W-1:0]      div_q;
    logic                  pre_q;
    logic                  done_q;
    logic [REG_W-1:0]      data_q;
    logic                  busy, finish, rise_tick, fall_tick;
    logic [DATA_W-1:0]     rd_data;
    logic                  ctrl_wr, data_wr, launch, rd_req;
    logic [ADDR_W-1:0]     dev_f, reg_f;
    logic [FRAME_BITS-1:0] frame_w;

    assign ctrl_wr = reg_wr && !reg_sel && !busy;
    assign data_wr = reg_wr && reg_sel && !busy;
    assign launch  = data_wr && reg_wdata[BIT_START];
    assign rd_req  = reg_wdata[BIT_READ];

    always_comb begin
        if (legacy_sel) begin
            dev_f = reg_wdata[26:22];
            reg_f = {1'b0, reg_wdata[21:18]};
        end else begin
            dev_f = reg_wdata[27:23];
            reg_f = reg_wdata[22:18];
        end
        frame_w = {2'b01, rd_req ? 2'b10 : 2'b01, dev_f, reg_f,
                   rd_req ? 2'b11 : 2'b10,
                   rd_req ? {DATA_W{1'b1}} : reg_wdata[DATA_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            pre_q  <= 1'b0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (ctrl_wr) begin
                div_q <= reg_wdata[DIV_W-1:0];
                pre_q <= reg_wdata[BIT_PRE_EN];
            end
            if (data_wr)
                data_q <= reg_wdata;
            else if (finish && rd_req_q)
                data_q[DATA_W-1:0] <= rd_data;
            if (launch)      done_q <= 1'b0;
            else if (finish) done_q <= 1'b1;
        end
    end

    logic rd_req_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_req_q <= 1'b0;
        else if (launch) rd_req_q <= rd_req;
    end

    assign reg_rdata = reg_sel ? data_q : {{PAD_W{1'b0}}, done_q, pre_q, div_q};

    mdio_clk_gen #(.DIV_W(DIV_W)) clk_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm #(
        .FRAME_W (FRAME_BITS),
        .PRE_W   (PREAMBLE_BITS),
        .DW      (DATA_W)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .frame_in  (frame_w),
        .rd_in     (rd_req),
        .pre_in    (pre_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .finish    (finish),
        .rd_data   (rd_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    assert_done_low_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_q);
    assert_busy_data_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_sel && !finish) |=> $stable(data_q));
    assert_busy_ctrl_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && !reg_sel) |=> ($stable(div_q) && $stable(pre_q)));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        legacy_sel = 1'b0;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b0;

    always #2.5 clk = ~clk;

    mdio_cmd_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .legacy_sel(legacy_sel),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int vec_cnt = 0;
    int miss_cnt = 0;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] en;
        int          n;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    int          cap_n = 0;
    int          pre_off = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_en = '0;
    logic [15:0] resp = '0;

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: assemble line bits on each rising management clock
    always @(posedge mdc) begin
        exp_t e;
        logic [63:0] m;
        cap_bits = {cap_bits[62:0], mdio_out};
        cap_en   = {cap_en[62:0], mdio_oe};
        cap_n++;
        if (sb_q.size() > 0 && cap_n == sb_q[0].n) begin
            e = sb_q.pop_front();
            m = (e.n >= 64) ? '1 : ((64'd1 << e.n) - 64'd1);
            check_eq(e.tag, "drive pattern", cap_en & m, e.en);
            check_eq(e.tag, "frame bits", cap_bits & e.en, e.bits & e.en);
        end
    end

    // transceiver model: present read data before each rising edge
    always @(negedge mdc) begin
        int p;
        p = cap_n - pre_off;
        if (p >= 16 && p <= 31) mdio_in = resp[31-p];
        else                    mdio_in = 1'b0;
    end

    function automatic logic [31:0] mkcmd(bit rd, bit legacy, logic [5:0] dev,
                                          logic [4:0] ra, logic [15:0] d);
        logic [31:0] w;
        w = '0;
        w[30] = 1'b1;
        w[29] = rd;
        w[28] = !rd;
        w[17] = 1'b1;
        if (legacy) begin
            w[27:22] = dev;
            w[21:18] = ra[3:0];
        end else begin
            w[27:23] = dev[4:0];
            w[22:18] = ra;
        end
        w[15:0] = d;
        return w;
    endfunction

    // expected frame per R4 and R8
    function automatic logic [31:0] exp_frame(logic [31:0] w, bit legacy);
        logic [4:0] dev, ra;
        bit rd;
        rd = w[29];
        if (legacy) begin
            dev = w[26:22];
            ra  = {1'b0, w[21:18]};
        end else begin
            dev = w[27:23];
            ra  = w[22:18];
        end
        return {2'b01, (rd ? 2'b10 : 2'b01), dev, ra, 2'b10, w[15:0]};
    endfunction

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
        #1;
    endtask

    task automatic run_cmd(string tag, logic [31:0] word, bit legacy, bit pre,
                           logic [6:0] div, logic [15:0] rsp, bit collide, bit midwrite);
        exp_t e;
        int n, t, k;
        bit got, rd;
        logic [31:0] expdata;
        rd = word[29];
        wr(1'b0, {24'h0, pre, div});
        n = pre ? 64 : 32;
        t = 2 * n * (int'(div) + 1);
        e.n = n;
        e.tag = tag;
        e.bits = pre ? {32'hFFFF_FFFF, exp_frame(word, legacy)} : {32'h0, exp_frame(word, legacy)};
        e.en = (n == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
        if (rd) e.en = e.en & ~64'h3FFFF;
        sb_q.push_back(e);
        cap_n = 0; pre_off = pre ? 32 : 0; resp = rsp; legacy_sel = legacy;
        @(negedge clk);
        reg_sel = 1'b1; reg_wdata = word; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
        #1;
        check_eq("R4", {tag, " flag cleared at launch"}, reg_rdata[8], 0);
        k = 0; got = 0;
        while (!got && k < t + 100) begin
            @(posedge clk); k++;
            @(negedge clk);
            reg_wr = 1'b0; reg_sel = 1'b0;
            #1;
            if (reg_rdata[8]) got = 1;
            else if ((collide && k == t - 1) || (midwrite && k == 5)) begin
                reg_sel = 1'b1; reg_wdata = 32'h5000_ABCD; reg_wr = 1'b1;
            end
        end
        check_eq("R5", {tag, " completion latency"}, k, t);
        check_eq(pre ? "R6" : "R5", {tag, " bit count"}, cap_n, n);
        reg_sel = 1'b1;
        #1;
        expdata = rd ? {word[31:16], rsp} : word;
        check_eq(rd ? "R7" : "R4", {tag, " command register"}, reg_rdata, expdata);
        reg_sel = 1'b0;
        if (collide || midwrite) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mdc !== 1'b0) got = 0;
            end
            #1;
            check_eq("R9", {tag, " no relaunch, flag held"}, {mdc, got, reg_rdata[8]}, 3'b011);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss_cnt++; vec_cnt++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_eq("R1", "settings after reset", reg_rdata, 0);
        reg_sel = 1'b1; #1;
        check_eq("R1", "command after reset", reg_rdata, 0);
        check_eq("R1", "line after reset", {mdc, mdio_oe}, 0);
        reg_sel = 1'b0;
        // R2 settings fields, flag not writable
        wr(1'b0, 32'hFFFF_FFFF);
        check_eq("R2", "settings readback", reg_rdata, 32'h0000_00FF);
        wr(1'b0, 32'h0000_0000);
        check_eq("R2", "settings cleared", reg_rdata, 0);
        // R3 store without start
        wr(1'b1, 32'h0123_4567);
        reg_sel = 1'b1; #1;
        check_eq("R3", "stored word", reg_rdata, 32'h0123_4567);
        reg_sel = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        check_eq("R3", "no frame, flag unchanged", {mdc, mdio_oe, reg_rdata[8]}, 0);
        // R4 plain write, current layout
        run_cmd("R4", mkcmd(0, 0, 6'h1F, 5'h01, 16'h00C0), 0, 0, 7'd2, 16'h0, 0, 0);
        // R7 read with preamble and completion-edge collision (R9)
        run_cmd("R7", mkcmd(1, 0, 6'h1D, 5'h01, 16'h0), 0, 1, 7'd2, 16'h4A5C, 1, 0);
        // R8 legacy write, fastest clock
        run_cmd("R8", mkcmd(0, 1, 6'h2B, 5'h0A, 16'h8001), 1, 0, 7'd0, 16'h0, 0, 0);
        // R9 legacy read with a write during the frame
        run_cmd("R9", mkcmd(1, 1, 6'h15, 5'h07, 16'h0), 1, 0, 7'd1, 16'hF00F, 0, 1);
        // R6 block select write with preamble
        run_cmd("R6", mkcmd(0, 0, 6'h00, 5'h1F, 16'h0010), 0, 1, 7'd0, 16'h0, 0, 0);
        // R10 quiet after everything
        repeat (10) @(negedge clk);
        check_eq("R10", "idle line", {mdc, mdio_oe}, 0);
        check_eq("R4", "scoreboard drained", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end
endmodule